// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block translates 32-bit virtual addresses into physical addresses for loads and stores, using a small fully associative set of mappings on 4 KiB pages. The low 12 bits of an address are the page offset. The upper 20 bits are the virtual page number. Each entry pairs a virtual page number with a 20-bit frame number and carries two control bits. The valid bit makes the entry usable. The write-enable bit allows stores through that entry. Lookup is combinational: hit, fault and physical address are all valid in the same cycle as the request.

The hardware never walks page tables. When a lookup finds no usable entry, or a store reaches an entry that does not permit writes, the unit signals a read or write fault and latches the full faulting address. Software then installs an entry through the refill port, at an index it chooses, and retries the access. On each successful access the unit records that the page was used. On each successful store it also records that the page was modified. Software can read back every field of every entry.

Top module: `swr_tlb`

## Requirements
- R1: On a hit, `paddr_o` equals the selected entry's frame number in bits 31:12, with `req_vaddr_i[11:0]` copied unchanged into bits 11:0. When there is no hit, `paddr_o` is zero.
- R2: A hit requires an entry whose valid bit is 1 and whose page number equals `req_vaddr_i[31:12]`. An entry that matches but has valid = 0 is treated as absent.
- R3: A load (`req_write_i`=0) that finds no usable entry raises `rd_fault_o`. A store (`req_write_i`=1) that finds no usable entry raises `wr_fault_o`. Either fault forces `hit_o` low.
- R4: On the clock edge that ends a faulting request, `bad_vaddr_o` captures the full request address. In any other cycle it holds its value.
- R5: A store that matches a valid entry whose write-enable bit is 0 raises `wr_fault_o` and no hit, captures the address, and leaves that entry's modified bit unchanged.
- R6: A hit sets the selected entry's use bit on the next edge. A store hit also sets its modified bit.
- R7: When `fill_en_i`=1, the next edge writes the page number, frame number, valid bit and write-enable bit into entry `fill_idx_i`, and clears that entry's use and modified bits. Read-back through `rd_idx_i` shows all six fields.
- R8: A refill and a status update aimed at the same entry in the same cycle leave the refill's values, with use and modified cleared. The lookup in that cycle still uses the old contents.
- R9: While `rst_ni` is low, every entry's valid, use and modified bits are 0, and `bad_vaddr_o` is 0.
- R10: When several valid entries match the same page, the entry with the lowest index supplies the translation and receives the status update.
- R11: When `req_valid_i` is 0, `hit_o`, `rd_fault_o` and `wr_fault_o` are all 0, and neither `bad_vaddr_o` nor any status bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_vaddr_i | input | 32 | Virtual address of the access |
| hit_o | output | 1 | Translation succeeded |
| paddr_o | output | 32 | Physical address (zero when there is no hit) |
| rd_fault_o | output | 1 | Load found no usable entry |
| wr_fault_o | output | 1 | Store found no usable entry, or the entry does not permit writes |
| bad_vaddr_o | output | 32 | Last faulting virtual address |
| fill_en_i | input | 1 | Refill write strobe |
| fill_idx_i | input | 2 | Entry index to refill |
| fill_vpn_i | input | 20 | Page number to install |
| fill_pfn_i | input | 20 | Frame number to install |
| fill_valid_i | input | 1 | Valid bit to install |
| fill_dirty_i | input | 1 | Write-enable bit to install |
| rd_idx_i | input | 2 | Entry index to read back |
| rd_vpn_o | output | 20 | Read-back page number |
| rd_pfn_o | output | 20 | Read-back frame number |
| rd_valid_o | output | 1 | Read-back valid bit |
| rd_dirty_o | output | 1 | Read-back write-enable bit |
| rd_use_o | output | 1 | Read-back use bit |
| rd_mod_o | output | 1 | Read-back modified bit |

## Verification
The bench installs an entry with the right page number but valid = 0. A design that ignores the valid bit would translate that access instead of faulting. It stores to a read-only page, where a faulty design would either let the store through or set the modified bit on a failed access. It places two valid entries with the same page number, so an arbitration that does not give precedence to the lowest index produces the wrong frame. It also refills an entry in the same cycle that the entry is hit: a design that gives priority to the status update would show a stale use bit after the refill. Idle requests whose addresses would fault are included as well, to catch a bad-address register or status bits that update without a request.

// File: rtl/swr_tlb_pkg.sv
package swr_tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = 20;
  localparam int PA_W  = PFN_W + OFF_W;
endpackage

// File: rtl/swr_tlb_entry.sv
module swr_tlb_entry
  import swr_tlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_valid_i,
  input  logic             fill_dirty_i,
  input  logic             touch_i,
  input  logic             store_i,
  output logic [VPN_W-1:0] vpn_o,
  output logic [PFN_W-1:0] pfn_o,
  output logic             valid_o,
  output logic             dirty_o,
  output logic             use_o,
  output logic             mod_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_o   <= '0;
      pfn_o   <= '0;
      valid_o <= 1'b0;
      dirty_o <= 1'b0;
      use_o   <= 1'b0;
      mod_o   <= 1'b0;
    end else if (fill_i) begin
      // refill wins over a same-cycle status update
      vpn_o   <= fill_vpn_i;
      pfn_o   <= fill_pfn_i;
      valid_o <= fill_valid_i;
      dirty_o <= fill_dirty_i;
      use_o   <= 1'b0;
      mod_o   <= 1'b0;
    end else if (touch_i) begin
      use_o <= 1'b1;
      if (store_i) mod_o <= 1'b1;
    end
  end

  // R8
  fill_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> (!use_o && !mod_o && vpn_o == $past(fill_vpn_i)));
  // R6
  touch_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_i && !fill_i) |=> use_o);
  // R6
  store_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_i && store_i && !fill_i) |=> mod_o);
  // R5
  mod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!touch_i && !fill_i) |=> ($stable(mod_o) && $stable(use_o)));
endmodule

// File: rtl/swr_tlb_match.sv
module swr_tlb_match
  import swr_tlb_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = 2
) (
  input  logic [VPN_W-1:0]              vpn_i,
  input  logic [NUM_ENT-1:0][VPN_W-1:0] ent_vpn_i,
  input  logic [NUM_ENT-1:0]            ent_valid_i,
  output logic [NUM_ENT-1:0]            sel_oh_o,
  output logic [IDX_W-1:0]              sel_idx_o,
  output logic                          any_o
);
  logic [NUM_ENT-1:0] match;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign match[g] = ent_valid_i[g] && (ent_vpn_i[g] == vpn_i);
  end

  // isolate lowest set bit
  assign sel_oh_o = match & (~match + 1'b1);
  assign any_o    = |match;

  always_comb begin
    sel_idx_o = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match[i]) sel_idx_o = IDX_W'(i);
    end
  end

  // R10
  always_comb sel_onehot_chk: assert ($onehot0(sel_oh_o));
  // R10
  always_comb sel_agree_chk: assert (!any_o || sel_oh_o[sel_idx_o]);
endmodule

// File: rtl/swr_tlb.sv
module swr_tlb
  import swr_tlb_pkg::*;
#(
  parameter  int NUM_ENT = 4,
  localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             hit_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             rd_fault_o,
  output logic             wr_fault_o,
  output logic [VA_W-1:0]  bad_vaddr_o,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_valid_i,
  input  logic             fill_dirty_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [VPN_W-1:0] rd_vpn_o,
  output logic [PFN_W-1:0] rd_pfn_o,
  output logic             rd_valid_o,
  output logic             rd_dirty_o,
  output logic             rd_use_o,
  output logic             rd_mod_o
);
  logic [NUM_ENT-1:0][VPN_W-1:0] ent_vpn;
  logic [NUM_ENT-1:0][PFN_W-1:0] ent_pfn;
  logic [NUM_ENT-1:0] ent_valid, ent_dirty, ent_use, ent_mod, sel_oh;
  logic [IDX_W-1:0]   sel_idx;
  logic               any_match, sel_dirty, fault;
  logic [PFN_W-1:0]   sel_pfn;

  swr_tlb_match #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_match (
    .vpn_i       (req_vaddr_i[VA_W-1:OFF_W]),
    .ent_vpn_i   (ent_vpn),
    .ent_valid_i (ent_valid),
    .sel_oh_o    (sel_oh),
    .sel_idx_o   (sel_idx),
    .any_o       (any_match)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    swr_tlb_entry u_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .fill_i       (fill_en_i && (fill_idx_i == IDX_W'(g))),
      .fill_vpn_i   (fill_vpn_i),
      .fill_pfn_i   (fill_pfn_i),
      .fill_valid_i (fill_valid_i),
      .fill_dirty_i (fill_dirty_i),
      .touch_i      (hit_o && sel_oh[g]),
      .store_i      (req_write_i),
      .vpn_o        (ent_vpn[g]),
      .pfn_o        (ent_pfn[g]),
      .valid_o      (ent_valid[g]),
      .dirty_o      (ent_dirty[g]),
      .use_o        (ent_use[g]),
      .mod_o        (ent_mod[g])
    );
  end

  always_comb begin
    sel_pfn    = ent_pfn[sel_idx];
    sel_dirty  = ent_dirty[sel_idx];
    hit_o      = req_valid_i && any_match && (!req_write_i || sel_dirty);
    rd_fault_o = req_valid_i && !req_write_i && !any_match;
    wr_fault_o = req_valid_i && req_write_i && !(any_match && sel_dirty);
    paddr_o    = hit_o ? {sel_pfn, req_vaddr_i[OFF_W-1:0]} : '0;
    fault      = rd_fault_o || wr_fault_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bad_vaddr_o <= '0;
    else if (fault) bad_vaddr_o <= req_vaddr_i;
  end

  assign rd_vpn_o   = ent_vpn[rd_idx_i];
  assign rd_pfn_o   = ent_pfn[rd_idx_i];
  assign rd_valid_o = ent_valid[rd_idx_i];
  assign rd_dirty_o = ent_dirty[rd_idx_i];
  assign rd_use_o   = ent_use[rd_idx_i];
  assign rd_mod_o   = ent_mod[rd_idx_i];

  // R4
  bad_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fault_o || wr_fault_o) |=> bad_vaddr_o == $past(req_vaddr_i));
  // R4
  bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_fault_o || wr_fault_o) |=> $stable(bad_vaddr_o));
  // R1
  hit_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> paddr_o[OFF_W-1:0] == req_vaddr_i[OFF_W-1:0]);
  // R3
  fault_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fault_o || wr_fault_o) |-> !hit_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!hit_o && !rd_fault_o && !wr_fault_o));
endmodule

// File: tb/swr_tlb_bench.sv
module swr_tlb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        hit, rd_fault, wr_fault;
  logic [31:0] paddr, bad_vaddr;
  logic        fill_en = 1'b0;
  logic [1:0]  fill_idx = '0, rd_idx = '0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic        fill_valid = 1'b0, fill_dirty = 1'b0;
  logic [19:0] rd_vpn, rd_pfn;
  logic        rd_valid, rd_dirty, rd_use, rd_mod;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_bad = '0;

  always #5 clk = ~clk;

  swr_tlb u_swr_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_vaddr_i(req_vaddr),
    .hit_o(hit), .paddr_o(paddr), .rd_fault_o(rd_fault), .wr_fault_o(wr_fault),
    .bad_vaddr_o(bad_vaddr),
    .fill_en_i(fill_en), .fill_idx_i(fill_idx), .fill_vpn_i(fill_vpn),
    .fill_pfn_i(fill_pfn), .fill_valid_i(fill_valid), .fill_dirty_i(fill_dirty),
    .rd_idx_i(rd_idx), .rd_vpn_o(rd_vpn), .rd_pfn_o(rd_pfn), .rd_valid_o(rd_valid),
    .rd_dirty_o(rd_dirty), .rd_use_o(rd_use), .rd_mod_o(rd_mod)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] va;
    logic        hit;
    logic        rdf;
    logic        wrf;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h12345678, 1'b1, 1'b0, 1'b0, 32'hABCDE678},
    '{1'b0, 32'h00003C9A, 1'b1, 1'b0, 1'b0, 32'h00000C9A},
    '{1'b1, 32'h00002F08, 1'b1, 1'b0, 1'b0, 32'h00004F08},
    '{1'b1, 32'h00003000, 1'b0, 1'b0, 1'b1, 32'h00000000},
    '{1'b0, 32'hFFFFF123, 1'b0, 1'b1, 1'b0, 32'h00000000},
    '{1'b1, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b1, 32'h00000000},
    '{1'b0, 32'h00000000, 1'b0, 1'b1, 1'b0, 32'h00000000},
    '{1'b1, 32'h12345FFF, 1'b1, 1'b0, 1'b0, 32'hABCDEFFF}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [1:0] idx, input logic [19:0] vpn,
                      input logic [19:0] pfn, input logic v, input logic d);
    @(negedge clk);
    fill_en = 1'b1; fill_idx = idx; fill_vpn = vpn; fill_pfn = pfn;
    fill_valid = v; fill_dirty = d;
    @(posedge clk); #1;
    fill_en = 1'b0;
  endtask

  // drive at negedge, sample combinational outputs 1 ns later
  task automatic start_req(input logic wr, input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = va;
    #1;
  endtask

  task automatic end_req();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic chk_entry(input string req, input logic [1:0] idx,
                           input logic v, input logic u, input logic m);
    rd_idx = idx; #1;
    chk(req, "valid", {31'd0, rd_valid}, {31'd0, v});
    chk(req, "use",   {31'd0, rd_use},   {31'd0, u});
    chk(req, "mod",   {31'd0, rd_mod},   {31'd0, m});
  endtask

  initial begin : watchdog
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #23;
    // R9: state under reset
    for (int i = 0; i < 4; i++) chk_entry("R9", 2'(i), 1'b0, 1'b0, 1'b0);
    chk("R9", "bad_vaddr", bad_vaddr, 32'h0);
    rst_n = 1'b1;

    // R11: idle request with faulting address
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b1; req_vaddr = 32'hDEAD0123; #1;
    chk("R11", "outs", {29'd0, hit, rd_fault, wr_fault}, 32'h0);
    @(posedge clk); #1;
    chk("R11", "bad_vaddr", bad_vaddr, 32'h0);

    // R7: install table used by the vectors
    fill(2'd0, 20'h12345, 20'hABCDE, 1'b1, 1'b1);
    fill(2'd1, 20'h00003, 20'h00000, 1'b1, 1'b0);
    fill(2'd2, 20'h00002, 20'h00004, 1'b1, 1'b1);
    fill(2'd3, 20'hFFFFF, 20'h00001, 1'b0, 1'b1);
    @(negedge clk);
    rd_idx = 2'd0; #1;
    chk("R7", "vpn", {12'd0, rd_vpn}, 32'h12345);
    chk("R7", "pfn", {12'd0, rd_pfn}, 32'hABCDE);
    chk("R7", "dirty", {31'd0, rd_dirty}, 32'h1);
    rd_idx = 2'd1; #1;
    chk("R7", "dirty1", {31'd0, rd_dirty}, 32'h0);

    // R1 R2 R3 R4 R5: vector walk
    for (int k = 0; k < NV; k++) begin
      start_req(VECS[k].wr, VECS[k].va);
      chk("R1", $sformatf("v%0d paddr", k), paddr, VECS[k].pa);
      chk("R2", $sformatf("v%0d hit", k), {31'd0, hit}, {31'd0, VECS[k].hit});
      chk("R3", $sformatf("v%0d rd_fault", k), {31'd0, rd_fault}, {31'd0, VECS[k].rdf});
      chk("R3", $sformatf("v%0d wr_fault", k), {31'd0, wr_fault}, {31'd0, VECS[k].wrf});
      if (VECS[k].rdf || VECS[k].wrf) exp_bad = VECS[k].va;
      end_req();
      chk("R4", $sformatf("v%0d bad_vaddr", k), bad_vaddr, exp_bad);
    end

    // R6 R5: status bits after the walk
    @(negedge clk);
    chk_entry("R6", 2'd0, 1'b1, 1'b1, 1'b1);
    chk_entry("R5", 2'd1, 1'b1, 1'b1, 1'b0);
    chk_entry("R6", 2'd2, 1'b1, 1'b1, 1'b1);
    chk_entry("R2", 2'd3, 1'b0, 1'b0, 1'b0);

    // R7 R2: refill entry 1 with a matching but invalid page
    fill(2'd1, 20'h00003, 20'h00000, 1'b0, 1'b0);
    @(negedge clk);
    chk_entry("R7", 2'd1, 1'b0, 1'b0, 1'b0);
    start_req(1'b0, 32'h00003C9A);
    chk("R2", "invalid match rd_fault", {31'd0, rd_fault}, 32'h1);
    chk("R2", "invalid match hit", {31'd0, hit}, 32'h0);
    end_req();
    chk("R4", "bad after load fault", bad_vaddr, 32'h00003C9A);
    fill(2'd1, 20'h00003, 20'h00000, 1'b1, 1'b0);
    start_req(1'b0, 32'h00003C9A);
    chk("R2", "retry hit", {31'd0, hit}, 32'h1);
    chk("R1", "retry paddr", paddr, 32'h00000C9A);
    end_req();

    // R10: duplicate page in entries 0 and 2
    fill(2'd0, 20'h00002, 20'h00007, 1'b1, 1'b1);
    start_req(1'b1, 32'h00002F08);
    chk("R10", "dup paddr", paddr, 32'h00007F08);
    end_req();
    @(negedge clk);
    chk_entry("R10", 2'd0, 1'b1, 1'b1, 1'b1);

    // R8: refill and hit on entry 0 in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_vaddr = 32'h00002004;
    fill_en = 1'b1; fill_idx = 2'd0; fill_vpn = 20'h00055;
    fill_pfn = 20'h00066; fill_valid = 1'b1; fill_dirty = 1'b0;
    #1;
    chk("R8", "old contents paddr", paddr, 32'h00007004);
    @(posedge clk); #1;
    req_valid = 1'b0; fill_en = 1'b0;
    @(negedge clk);
    rd_idx = 2'd0; #1;
    chk("R8", "vpn", {12'd0, rd_vpn}, 32'h00055);
    chk("R8", "pfn", {12'd0, rd_pfn}, 32'h00066);
    chk_entry("R8", 2'd0, 1'b1, 1'b0, 1'b0);

    // R11: idle cycle keeps status and bad address
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_vaddr = 32'h00055ABC;
    @(posedge clk); #1;
    chk("R11", "bad hold", bad_vaddr, 32'h00003C9A);
    chk_entry("R11", 2'd0, 1'b1, 1'b0, 1'b0);

    // R9: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0; #1;
    for (int i = 0; i < 4; i++) chk_entry("R9", 2'(i), 1'b0, 1'b0, 1'b0);
    chk("R9", "bad reset", bad_vaddr, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule